// File: doc/BRIEF.md
# BCD Calendar Clock Register Block with Coherent Snapshot

This block keeps wall-clock time and date as seven packed-BCD counters: seconds, minutes, hours, day of month, month, two-digit year (years since 2000) and weekday. A prescaler counts a slow periodic tick, nominally 32.768 kHz and arriving as a one-cycle enable in the system clock domain. It advances the seconds once every `TICKS_PER_SEC` ticks, and carries ripple through the calendar, including month lengths and leap years.

Software reaches the block through a byte-wide register port with a combinational read. It sets a halt bit to freeze counting while it writes a new time. A request bit copies the running time into a set of shadow registers. A select bit then makes reads of the time registers return that frozen copy, so a read of several bytes is taken from one instant. A status register collects seven event flags that software clears by writing ones.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, weekday 6. The control register and the status register both read 0x00.
- R2: The time registers sit at TIME_BASE+0..6 in the order seconds, minutes, hours, day, month, year, weekday. Control is at CTRL_ADDR (8) and status at STAT_ADDR (9). Other addresses read 0x00. Loaded values are ANDed with the field masks 0x7F, 0x7F, 0x3F, 0x3F, 0x1F, 0xFF, 0x07 in that order.
- R3: While running, seconds advance once every TICKS_PER_SEC tick pulses. Seconds and minutes wrap from 0x59 to 0x00 and hours from 0x23 to 0x00, and each wrap carries into the next field.
- R4: The day wraps to 0x01 after 0x30 in months 04, 06, 09 and 0x11, after 0x31 in the other months, and after 0x28 or 0x29 in month 02. February has 0x29 days when the year is divisible by 4. Month 0x12 wraps to 0x01 with a year increment, and year 0x99 wraps to 0x00.
- R5: The weekday advances with the day and goes from 6 to 0. A weekday write whose masked value is 7 stores 0.
- R6: Control bit 0 (halt) holds all counters and the prescaler. While it is 1, writes to a time register load that field.
- R7: Writes to the time registers while the halt bit is 0 are ignored.
- R8: A 0-to-1 write of control bit 6 (capture request) copies the live time into the shadow registers. The copy happens at the first clock edge after the write at which the seconds do not advance.
- R9: Control bit 7 (shadow select) set makes time reads return the shadow copy, and clear makes them return the live counters. Control reads back bits 7, 6 and 0, with the other bits at 0.
- R10: A 1 on flag_set[k] sets status bit k+1. Writing a 1 to status bits 7:1 clears those bits, and a set in the same cycle wins. Status bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per slow oscillator period |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| flag_set | input | 7 | Event inputs that set status bits 7:1 |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |

## Verification
A carry that goes wrong inside the calendar shows up only when that field is read at the next second boundary. So the bench compares the read port with its model on every clock, and it also runs each month-end, leap-year and year-wrap case to the point where the day changes. A shadow copy taken on the wrong edge shows up as a value that differs by one second from the model, and it persists until the next capture. A lost capture request leaves the shadow holding its previous contents indefinitely. A wrong prescaler phase shifts every later seconds transition by whole cycles, and the per-cycle comparison catches this at the first one.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   localparam int NFIELD = 7;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;
   localparam int F_WDAY = 6;

   typedef logic [NFIELD-1:0][7:0] rtc_time_t;

   localparam rtc_time_t RESET_TIME = {8'h06, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   function automatic logic [7:0] field_mask(input logic [2:0] idx);
      case (idx)
         3'd0, 3'd1: return 8'h7F;
         3'd2, 3'd3: return 8'h3F;
         3'd4:       return 8'h1F;
         3'd5:       return 8'hFF;
         3'd6:       return 8'h07;
         default:    return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic logic leap_year(input logic [7:0] y);
      logic [5:0] s;
      s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   output logic sec_pulse
);

   if (TICKS_PER_SEC < 1) begin : g_bad
      $error("TICKS_PER_SEC must be at least 1");
   end

   if (TICKS_PER_SEC == 1) begin : g_direct
      assign sec_pulse = tick & run;
   end else begin : g_count
      localparam int CW = $clog2(TICKS_PER_SEC);
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt_q <= '0;
         else if (tick && run) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign sec_pulse = tick && run && (cnt_q == LAST);
   end

   // R6
   pulse_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> (tick && run));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import bcd_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      load_en,
   input  logic [2:0] load_idx,
   input  logic [7:0] load_val,
   output rtc_time_t now
);

   rtc_time_t now_q, nxt;
   logic [7:0] lv;
   logic c_min, c_hr, c_day, c_mon, c_yr;

   always_comb begin
      lv = load_val & field_mask(load_idx);
      if (load_idx == 3'(F_WDAY) && lv == 8'h07) lv = 8'h00;
   end

   always_comb begin
      nxt   = now_q;
      c_min = 1'b0;
      c_hr  = 1'b0;
      c_day = 1'b0;
      c_mon = 1'b0;
      c_yr  = 1'b0;
      if (load_en) begin
         nxt[load_idx] = lv;
      end else if (adv) begin
         c_min = (now_q[F_SEC] >= 8'h59);
         nxt[F_SEC] = c_min ? 8'h00 : bcd_inc(now_q[F_SEC]);
         if (c_min) begin
            c_hr = (now_q[F_MIN] >= 8'h59);
            nxt[F_MIN] = c_hr ? 8'h00 : bcd_inc(now_q[F_MIN]);
         end
         if (c_hr) begin
            c_day = (now_q[F_HOUR] >= 8'h23);
            nxt[F_HOUR] = c_day ? 8'h00 : bcd_inc(now_q[F_HOUR]);
         end
         if (c_day) begin
            nxt[F_WDAY] = (now_q[F_WDAY] >= 8'h06) ? 8'h00 : now_q[F_WDAY] + 8'd1;
            c_mon = (now_q[F_DAY] >= month_days(now_q[F_MON], now_q[F_YEAR]));
            nxt[F_DAY] = c_mon ? 8'h01 : bcd_inc(now_q[F_DAY]);
         end
         if (c_mon) begin
            c_yr = (now_q[F_MON] >= 8'h12);
            nxt[F_MON] = c_yr ? 8'h01 : bcd_inc(now_q[F_MON]);
         end
         if (c_yr) begin
            nxt[F_YEAR] = (now_q[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(now_q[F_YEAR]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= RESET_TIME;
      else        now_q <= nxt;
   end

   assign now = now_q;

   // R3
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load_en && now_q[F_SEC] == 8'h59) |=> (now_q[F_SEC] == 8'h00));

   // R5
   wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      now_q[F_WDAY] != 8'h07);

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
   import bcd_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_rise,
   input  logic      adv,
   input  rtc_time_t live,
   output rtc_time_t shadow
);

   logic      pend_q;
   logic      take;
   rtc_time_t shadow_q;

   assign take = pend_q && !adv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         shadow_q <= RESET_TIME;
      end else begin
         if (take) shadow_q <= live;
         if (req_rise)  pend_q <= 1'b1;
         else if (take) pend_q <= 1'b0;
      end
   end

   assign shadow = shadow_q;

   // R8
   capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !adv) |=> (shadow_q == $past(live)));

   // R8
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !adv && !req_rise) |=> !pend_q);

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
   import bcd_rtc_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int TICKS_PER_SEC = 32768,
   parameter int TIME_BASE     = 0,
   parameter int CTRL_ADDR     = 8,
   parameter int STAT_ADDR     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   input  logic [6:0]        flag_set,
   output logic [7:0]        reg_rdata
);

   localparam int SPAN = 1 << ADDR_W;

   if (TIME_BASE + NFIELD > SPAN || CTRL_ADDR >= SPAN || STAT_ADDR >= SPAN) begin : g_range
      $error("register map does not fit ADDR_W");
   end
   if ((CTRL_ADDR >= TIME_BASE && CTRL_ADDR < TIME_BASE + NFIELD) ||
       (STAT_ADDR >= TIME_BASE && STAT_ADDR < TIME_BASE + NFIELD) ||
       CTRL_ADDR == STAT_ADDR) begin : g_overlap
      $error("register map overlaps");
   end

   logic [ADDR_W-1:0] offs;
   logic              is_time, is_ctrl, is_stat;
   logic [2:0]        idx;
   logic              halt_q, get_q, rsel_q;
   logic [6:0]        stat_q, stat_clr;
   logic              adv, load_en, req_rise;
   rtc_time_t         live, shadow, src;

   assign offs    = reg_addr - ADDR_W'(TIME_BASE);
   assign is_time = (offs < ADDR_W'(NFIELD));
   assign idx     = offs[2:0];
   assign is_ctrl = (reg_addr == ADDR_W'(CTRL_ADDR));
   assign is_stat = (reg_addr == ADDR_W'(STAT_ADDR));

   assign load_en  = reg_wr && is_time && halt_q;
   assign req_rise = reg_wr && is_ctrl && reg_wdata[6] && !get_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         get_q  <= 1'b0;
         rsel_q <= 1'b0;
      end else if (reg_wr && is_ctrl) begin
         halt_q <= reg_wdata[0];
         get_q  <= reg_wdata[6];
         rsel_q <= reg_wdata[7];
      end
   end

   assign stat_clr = (reg_wr && is_stat) ? reg_wdata[7:1] : 7'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~stat_clr) | flag_set;
   end

   rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) presc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (!halt_q),
      .sec_pulse(adv)
   );

   rtc_calendar cal_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .load_en (load_en),
      .load_idx(idx),
      .load_val(reg_wdata),
      .now     (live)
   );

   rtc_snapshot snap_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_rise(req_rise),
      .adv     (adv),
      .live    (live),
      .shadow  (shadow)
   );

   assign src = rsel_q ? shadow : live;

   always_comb begin
      if (is_time)      reg_rdata = src[idx];
      else if (is_ctrl) reg_rdata = {rsel_q, get_q, 5'd0, halt_q};
      else if (is_stat) reg_rdata = {stat_q, 1'b0};
      else              reg_rdata = 8'h00;
   end

   // R6
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !load_en) |=> $stable(live));

   // R7
   run_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_q && !adv) |=> $stable(live));

   // R10
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_set) |=> ((stat_q & $past(flag_set)) == $past(flag_set)));

endmodule

// File: tb/bcd_rtc_regs_tb_top.sv
module bcd_rtc_regs_tb_top;

   localparam int TPS  = 4;
   localparam int CTRL = 8;
   localparam int STAT = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [6:0] flag_set = '0;
   logic [7:0] reg_rdata;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;
   bit  tick_on = 1'b0, tick_slow = 1'b0, tick_ph = 1'b0;

   int  lv[7], sh[7];
   int  m_pre;
   bit  m_halt, m_get, m_rsel, m_pend;
   bit  [6:0] m_stat;

   always #2 clk = ~clk;

   bcd_rtc_regs #(.TICKS_PER_SEC(TPS)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .flag_set(flag_set),
      .reg_rdata(reg_rdata)
   );

   always @(negedge clk) begin
      tick_ph <= ~tick_ph;
      tick    <= tick_on && (!tick_slow || tick_ph);
   end

   function automatic int b2d(logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction
   function automatic logic [7:0] d2b(int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction
   function automatic logic [7:0] fmask(int i);
      case (i)
         0, 1: return 8'h7F;
         2, 3: return 8'h3F;
         4:    return 8'h1F;
         5:    return 8'hFF;
         default: return 8'h07;
      endcase
   endfunction
   function automatic int mdays(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] model_read(logic [3:0] a);
      if (a < 7) return d2b(m_rsel ? sh[a] : lv[a]);
      if (a == CTRL) return {m_rsel, m_get, 5'd0, m_halt};
      if (a == STAT) return {m_stat, 1'b0};
      return 8'h00;
   endfunction

   task automatic model_reset();
      lv = '{0, 0, 0, 1, 1, 0, 6};
      sh = lv;
      m_pre = 0; m_halt = 0; m_get = 0; m_rsel = 0; m_pend = 0; m_stat = '0;
   endtask

   task automatic model_advance();
      lv[0]++;
      if (lv[0] < 60) return;
      lv[0] = 0; lv[1]++;
      if (lv[1] < 60) return;
      lv[1] = 0; lv[2]++;
      if (lv[2] < 24) return;
      lv[2] = 0;
      lv[6] = (lv[6] >= 6) ? 0 : lv[6] + 1;
      if (lv[3] < mdays(lv[4], lv[5])) begin lv[3]++; return; end
      lv[3] = 1;
      if (lv[4] < 12) begin lv[4]++; return; end
      lv[4] = 1;
      lv[5] = (lv[5] >= 99) ? 0 : lv[5] + 1;
   endtask

   task automatic model_step();
      bit adv, cap, rise;
      int v;
      adv  = !m_halt && tick && (m_pre == TPS - 1);
      cap  = m_pend && !adv;
      rise = reg_wr && reg_addr == CTRL && reg_wdata[6] && !m_get;
      if (cap) sh = lv;
      if (rise) m_pend = 1; else if (cap) m_pend = 0;
      if (!m_halt && tick) m_pre = (m_pre == TPS - 1) ? 0 : m_pre + 1;
      if (adv) model_advance();
      if (reg_wr && m_halt && reg_addr < 7) begin
         v = b2d(reg_wdata & fmask(int'(reg_addr)));
         if (reg_addr == 6 && v == 7) v = 0;
         lv[reg_addr] = v;
      end
      if (reg_wr && reg_addr == CTRL) begin
         m_halt = reg_wdata[0]; m_get = reg_wdata[6]; m_rsel = reg_wdata[7];
      end
      m_stat = (m_stat & ~((reg_wr && reg_addr == STAT) ? reg_wdata[7:1] : 7'd0)) | flag_set;
   endtask

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, reg_addr, act, exp);
      end
   endtask

   // every-cycle comparison against the reference model
   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
      #1;
      if (rst_n && !done) begin
         if (reg_addr < 7)          check("R3", reg_rdata, model_read(reg_addr));
         else if (reg_addr == CTRL) check("R9", reg_rdata, model_read(reg_addr));
         else if (reg_addr == STAT) check("R10", reg_rdata, model_read(reg_addr));
         else                       check("R2", reg_rdata, model_read(reg_addr));
      end
   end

   task automatic wr_reg(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic expect_rd(logic [3:0] a, logic [7:0] exp, string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic load_time(logic [6:0][7:0] t);
      wr_reg(CTRL, 8'h01);
      for (int i = 0; i < 7; i++) wr_reg(4'(i), t[i]);
   endtask

   // load t, run until field wi changes, halt, check fields 1..6
   task automatic roll(logic [6:0][7:0] t, int wi, logic [6:0][7:0] e, string tag);
      load_time(t);
      tick_on = 1'b1; tick_slow = 1'b0;
      wr_reg(CTRL, 8'h00);
      reg_addr = 4'(wi);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk); #1;
         if (reg_rdata != t[wi]) break;
      end
      wr_reg(CTRL, 8'h01);
      for (int i = 1; i < 7; i++) expect_rd(4'(i), e[i], tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 7; i++) expect_rd(4'(i), (i == 3 || i == 4) ? 8'h01 : (i == 6) ? 8'h06 : 8'h00, "R1");
      expect_rd(CTRL, 8'h00, "R1");
      expect_rd(STAT, 8'h00, "R1");
      expect_rd(4'd12, 8'h00, "R2");
      // free run through minute wraps, every cycle and every other cycle
      tick_on = 1'b1;
      reg_addr = 0;
      repeat (300) @(negedge clk);
      tick_slow = 1'b1;
      reg_addr = 1;
      repeat (300) @(negedge clk);
      // R3 hour carry from 00:59:59
      roll({8'h06, 8'h00, 8'h01, 8'h01, 8'h00, 8'h59, 8'h59}, 2,
           {8'h06, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00}, "R3");
      // R4 leap February 2024
      roll({8'h03, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59}, 3,
           {8'h04, 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00}, "R4");
      // R4 common February 2023
      roll({8'h02, 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59}, 3,
           {8'h03, 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00}, "R4");
      // R4 thirty-day month 11
      roll({8'h01, 8'h25, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59}, 3,
           {8'h02, 8'h25, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00}, "R4");
      // R4 thirty-day month 04
      roll({8'h05, 8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59}, 3,
           {8'h06, 8'h25, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00}, "R4");
      // R4 thirty-one-day month 01 holds at 0x31 rather than wrapping at 30
      roll({8'h04, 8'h25, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59}, 3,
           {8'h05, 8'h25, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00}, "R4");
      // R4 and R5 year wrap with weekday 6 to 0
      roll({8'h06, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59}, 3,
           {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00}, "R5");
      // R2 masks and R5 weekday 7 forced to 0 (halt still set)
      wr_reg(0, 8'hD9); expect_rd(0, 8'h59, "R2");
      wr_reg(4, 8'hE5); expect_rd(4, 8'h05, "R2");
      wr_reg(2, 8'hC3); expect_rd(2, 8'h03, "R2");
      wr_reg(6, 8'h0F); expect_rd(6, 8'h00, "R5");
      // R6 halt holds with tick running
      wr_reg(0, 8'h10);
      tick_on = 1'b1; tick_slow = 1'b0;
      repeat (40) @(negedge clk);
      expect_rd(0, 8'h10, "R6");
      expect_rd(2, 8'h03, "R6");
      // R7 write ignored while running (tick off so nothing advances)
      tick_on = 1'b0;
      wr_reg(CTRL, 8'h00);
      wr_reg(0, 8'h33);
      expect_rd(0, 8'h10, "R7");
      // R8 capture while halted, R9 shadow read while running
      load_time({8'h02, 8'h21, 8'h07, 8'h15, 8'h10, 8'h20, 8'h30});
      wr_reg(CTRL, 8'hC1);
      wr_reg(CTRL, 8'h80);
      tick_on = 1'b1;
      repeat (40) @(negedge clk);
      expect_rd(0, 8'h30, "R8");
      expect_rd(1, 8'h20, "R8");
      expect_rd(CTRL, 8'h80, "R9");
      repeat (20) @(negedge clk);
      expect_rd(0, 8'h30, "R9");
      wr_reg(CTRL, 8'h00);
      @(negedge clk); reg_addr = 0; #1;
      n_chk++;
      if (reg_rdata == 8'h30) begin
         n_fail++;
         $display("FAIL R9 live read actual=%02h expected not 30", reg_rdata);
      end
      // R8 second capture while running (checked by model)
      wr_reg(CTRL, 8'h40);
      wr_reg(CTRL, 8'hC0);
      repeat (30) @(negedge clk);
      wr_reg(CTRL, 8'h80);
      repeat (30) @(negedge clk);
      tick_on = 1'b0;
      // R10 status set / clear
      @(negedge clk); flag_set = 7'b0000101;
      @(negedge clk); flag_set = '0;
      expect_rd(STAT, 8'h0A, "R10");
      wr_reg(STAT, 8'h03);
      expect_rd(STAT, 8'h08, "R10");
      @(negedge clk);
      reg_addr = STAT; reg_wr = 1'b1; reg_wdata = 8'h08; flag_set = 7'b0000100;
      @(negedge clk);
      reg_wr = 1'b0; flag_set = '0;
      expect_rd(STAT, 8'h08, "R10");
      wr_reg(STAT, 8'hFF);
      expect_rd(STAT, 8'h00, "R10");
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule